// File: doc/BRIEF.md
# Third-Order Decimating Cascaded Integrator-Comb Filter

This block lowers the sample rate of a signed 16-bit stream by a fixed factor of eight. It uses no multipliers. Three running-sum (integrator) stages work at the input rate. A rate counter picks every eighth integrator result. Three first-difference (comb) stages, each with a one-sample delay, then work on the picked values. The result keeps the full bit growth of the filter, which is nine extra bits. The output is therefore a signed 25-bit word with a DC gain of exactly 512.

Samples enter through a valid/ready handshake and are meant to arrive at the clock rate. The output port carries only a valid strobe and data. Each output appears as a single-cycle pulse. The downstream logic must take the data in that cycle; it cannot stall the filter. Any scaling back to 16 bits is done by the user.

Top module: `cic_decim`

## Requirements
- R1: Three integrators and three combs (differential delay 1) are in cascade. Output number m (counting from 0 after reset) equals the sum over j of h[j]·x[8m+7−j]. Here x[k] is the k-th accepted input (zero for k<0), and h[j] are the 22 coefficients of (1+z⁻¹+…+z⁻⁷)³.
- R2: Exactly one output is produced for every eight accepted inputs. The first output follows the eighth accepted input after reset, and fewer than eight accepted inputs produce no output.
- R3: The output is 25-bit two's complement. A constant input c settles to exactly 512·c, including c = −32768 and c = 32767.
- R4: An input is consumed only at a clock edge where s_valid and s_ready are both high. Data presented while s_valid is low has no effect on any output.
- R5: m_valid rises 15 cycles after the clock edge that accepts the eighth input of a group.
- R6: m_valid is high for one cycle per output and is never high in two consecutive cycles.
- R7: Integrators and combs wrap modulo 2²⁵. Long full-scale runs whose running sums overflow still give the exact result of R1.
- R8: While the synchronous active-low reset is held, s_ready and m_valid are low and all filter state clears. From the first cycle after release, s_ready stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Input sample offered |
| s_ready | output | 1 | Filter can take a sample |
| s_data | input | 16 | Signed input sample |
| m_valid | output | 1 | One-cycle strobe marking an output sample |
| m_data | output | 25 | Signed full-precision output sample |

## Verification
The tests use the following input patterns:

- **Unit impulse.** Output values are compared with coefficients computed by repeated convolution in the bench, which shows that the response has the right shape and decimation phase.
- **Scaled negative impulse.** This checks sign handling.
- **Constant inputs, including both full-scale extremes.** These show the 512 gain and show that integrator wraparound cancels.
- **Pseudo-random stream with idle gaps.** Junk data is driven while s_valid is low, so a design that consumed samples without a handshake would give wrong outputs.
- **Partial group of seven samples.** This separates correct output counting from early emission.

Output timing is measured against the recorded edge of every eighth acceptance.

// File: rtl/cic_pkg.sv
package cic_pkg;

   function automatic int clog2_int(input int v);
      int r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

   function automatic int cic_growth_width(input int in_w, input int stages, input int rate);
      return in_w + stages * clog2_int(rate);
   endfunction

endpackage

// File: rtl/cic_integ_bank.sv
module cic_integ_bank #(
   parameter int W      = 25,
   parameter int STAGES = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] x_in,
   output logic [W-1:0] last_next
);
   logic [STAGES-1:0][W-1:0] acc;
   logic [STAGES-1:0][W-1:0] nxt;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         assign nxt[i] = acc[i] + x_in;
      end else begin : g_tail
         assign nxt[i] = acc[i] + nxt[i-1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)  acc[i] <= '0;
         else if (en) acc[i] <= nxt[i];
      end
   end

   assign last_next = nxt[STAGES-1];
endmodule

// File: rtl/cic_rate_ctr.sv
module cic_rate_ctr #(
   parameter int RATE = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic frame_done
);
   localparam int CW = (RATE > 2) ? $clog2(RATE) : 1;
   localparam logic [CW-1:0] LAST = CW'(RATE - 1);

   logic [CW-1:0] cnt;

   assign frame_done = en && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (frame_done) cnt <= '0;
      else if (en)         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/cic_comb_bank.sv
module cic_comb_bank #(
   parameter int W      = 25,
   parameter int STAGES = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] x_in,
   output logic         y_valid,
   output logic [W-1:0] y_out
);
   logic [STAGES-1:0][W-1:0] dly;
   logic [STAGES-1:0][W-1:0] dif;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic [W-1:0] stage_in;
      if (i == 0) begin : g_head
         assign stage_in = x_in;
      end else begin : g_tail
         assign stage_in = dif[i-1];
      end
      assign dif[i] = stage_in - dly[i];
      always_ff @(posedge clk) begin
         if (!rst_n)  dly[i] <= '0;
         else if (en) dly[i] <= stage_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_valid <= 1'b0;
         y_out   <= '0;
      end else begin
         y_valid <= en;
         if (en) y_out <= dif[STAGES-1];
      end
   end
endmodule

// File: rtl/cic_delay_line.sv
module cic_delay_line #(
   parameter int W     = 25,
   parameter int DEPTH = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         v_in,
   input  logic [W-1:0] d_in,
   output logic         v_out,
   output logic [W-1:0] d_out
);
   if (DEPTH == 0) begin : g_wire
      assign v_out = v_in;
      assign d_out = d_in;
   end else begin : g_regs
      logic [DEPTH-1:0]        vs;
      logic [DEPTH-1:0][W-1:0] ds;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vs <= '0;
            ds <= '0;
         end else begin
            vs[0] <= v_in;
            ds[0] <= d_in;
            for (int k = 1; k < DEPTH; k++) begin
               vs[k] <= vs[k-1];
               ds[k] <= ds[k-1];
            end
         end
      end
      assign v_out = vs[DEPTH-1];
      assign d_out = ds[DEPTH-1];
   end
endmodule

// File: rtl/cic_decim.sv
module cic_decim #(
   parameter int IN_W    = 16,
   parameter int STAGES  = 3,
   parameter int RATE    = 8,
   parameter int LATENCY = 15,
   parameter int OUT_W   = cic_pkg::cic_growth_width(IN_W, STAGES, RATE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_valid,
   output logic             s_ready,
   input  logic [IN_W-1:0]  s_data,
   output logic             m_valid,
   output logic [OUT_W-1:0] m_data
);
   localparam int CORE_LAT = 1;
   localparam int PAD      = LATENCY - CORE_LAT;

   if (RATE < 2 || (RATE & (RATE - 1)) != 0) begin : g_bad_rate
      $error("cic_decim: RATE must be a power of two of at least 2");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("cic_decim: STAGES must be at least 1");
   end
   if (PAD < 0) begin : g_bad_lat
      $error("cic_decim: LATENCY below the intrinsic pipeline depth");
   end
   if (OUT_W != cic_pkg::cic_growth_width(IN_W, STAGES, RATE)) begin : g_bad_w
      $error("cic_decim: OUT_W must equal the full bit growth");
   end

   logic             rdy_q;
   logic             take;
   logic             frame_done;
   logic [OUT_W-1:0] x_ext;
   logic [OUT_W-1:0] integ_next;
   logic             dec_v;
   logic [OUT_W-1:0] dec_q;
   logic             comb_v;
   logic [OUT_W-1:0] comb_d;

   always_ff @(posedge clk) begin
      if (!rst_n) rdy_q <= 1'b0;
      else        rdy_q <= 1'b1;
   end
   assign s_ready = rdy_q;
   assign take    = s_valid && rdy_q;
   assign x_ext   = {{(OUT_W-IN_W){s_data[IN_W-1]}}, s_data};

   cic_integ_bank #(.W(OUT_W), .STAGES(STAGES)) i_integ (
      .clk(clk), .rst_n(rst_n), .en(take), .x_in(x_ext), .last_next(integ_next)
   );

   cic_rate_ctr #(.RATE(RATE)) i_rate (
      .clk(clk), .rst_n(rst_n), .en(take), .frame_done(frame_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_v <= 1'b0;
         dec_q <= '0;
      end else begin
         dec_v <= frame_done;
         if (frame_done) dec_q <= integ_next;
      end
   end

   cic_comb_bank #(.W(OUT_W), .STAGES(STAGES)) i_comb (
      .clk(clk), .rst_n(rst_n), .en(dec_v), .x_in(dec_q),
      .y_valid(comb_v), .y_out(comb_d)
   );

   cic_delay_line #(.W(OUT_W), .DEPTH(PAD)) i_align (
      .clk(clk), .rst_n(rst_n), .v_in(comb_v), .d_in(comb_d),
      .v_out(m_valid), .d_out(m_data)
   );
endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk #(
   parameter int RATE    = 8,
   parameter int LATENCY = 15
) (
   input logic clk,
   input logic rst_n,
   input logic s_valid,
   input logic s_ready,
   input logic m_valid
);
   localparam int CW = (RATE > 2) ? $clog2(RATE) : 1;

   logic [CW-1:0]    seen;
   logic [LATENCY:0] due;
   logic             grp_end;

   assign grp_end = s_valid && s_ready && (seen == CW'(RATE - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen <= '0;
         due  <= '0;
      end else begin
         if (s_valid && s_ready) seen <= grp_end ? '0 : seen + 1'b1;
         due <= {due[LATENCY-1:0], grp_end};
      end
   end

   // R8: handshake held off while reset is applied
   assert_ready_low_in_reset_R8: assert property (@(posedge clk)
      !rst_n |=> !s_ready);
   assert_valid_low_in_reset_R8: assert property (@(posedge clk)
      !rst_n |=> !m_valid);
   // R8: ready stays up once reset has been released for a cycle
   assert_ready_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> s_ready);
   // R6: single-cycle output strobe
   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |=> !m_valid);
   // R2 and R5: each output lands exactly LATENCY cycles after a completed group
   assert_output_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid == due[LATENCY]);
endmodule

bind cic_decim cic_decim_chk #(.RATE(RATE), .LATENCY(LATENCY)) i_chk (
   .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .m_valid(m_valid)
);

// File: tb/test_cic_decim.sv
module test_cic_decim;
   localparam int NMAX = 256;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               s_valid = 1'b0;
   logic               s_ready;
   logic signed [15:0] s_data = '0;
   logic               m_valid;
   logic [24:0]        m_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   logic signed [15:0] xs [NMAX];
   longint             h [22];
   logic signed [24:0] outs [NMAX/8];
   int                 ocyc [NMAX/8];
   int                 fcyc [NMAX/8];
   int                 ocnt;
   int                 acc_n;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cic_decim i_cic_decim (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
      .s_data(s_data), .m_valid(m_valid), .m_data(m_data)
   );

   always @(negedge clk) begin
      if (rst_n && m_valid && ocnt < NMAX/8) begin
         outs[ocnt] = $signed(m_data);
         ocyc[ocnt] = cyc;
         ocnt = ocnt + 1;
      end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic signed [24:0] expect_out(input int m, input int n);
      longint s = 0;
      for (int j = 0; j < 22; j++) begin
         int k = 8*m + 7 - j;
         if (k >= 0 && k < n) s += h[j] * longint'(xs[k]);
      end
      return s[24:0];
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      s_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(!s_ready && !m_valid, "R8 ready/valid low in reset", {s_ready, m_valid}, 0);
      rst_n = 1'b1;
      ocnt = 0;
      acc_n = 0;
      @(negedge clk);
      check(s_ready, "R8 ready high after release", s_ready, 1);
   endtask

   task automatic feed_one(input logic signed [15:0] d);
      s_valid = 1'b1;
      s_data  = d;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      acc_n++;
      if (acc_n % 8 == 0) fcyc[acc_n/8 - 1] = cyc;
      s_valid = 1'b0;
      s_data  = 16'sh7FFF;
   endtask

   task automatic run_seg(input string name, input int n, input bit gaps);
      do_reset();
      for (int i = 0; i < n; i++) begin
         if (gaps && (i % 3 == 1)) begin
            s_valid = 1'b0;
            s_data  = (i % 2) ? 16'sh7FFF : -16'sh7000;
            repeat (2) @(negedge clk);
         end
         feed_one(xs[i]);
      end
      repeat (24) @(negedge clk);
      check(ocnt == n/8, {name, " R2 output count"}, ocnt, n/8);
      for (int m = 0; m < ocnt && m < n/8; m++) begin
         check(outs[m] == expect_out(m, n), {name, " R1 R4 R7 sample value"},
               outs[m], expect_out(m, n));
         check(ocyc[m] - fcyc[m] == 15, {name, " R5 latency"}, ocyc[m] - fcyc[m], 15);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      longint h2 [15];
      for (int i = 0; i < 15; i++) h2[i] = 0;
      for (int i = 0; i < 22; i++) h[i] = 0;
      for (int a = 0; a < 8; a++) for (int b = 0; b < 8; b++) h2[a+b] += 1;
      for (int a = 0; a < 15; a++) for (int b = 0; b < 8; b++) h[a+b] += h2[a];

      // R1: unit impulse, with idle gaps carrying junk (R4)
      for (int i = 0; i < NMAX; i++) xs[i] = '0;
      xs[0] = 16'sd1;
      run_seg("impulse", 40, 1'b1);
      check(outs[1] == 25'(h[15]), "R1 impulse phase", outs[1], h[15]);

      // R1: scaled negative impulse, continuous
      for (int i = 0; i < NMAX; i++) xs[i] = '0;
      xs[3] = -16'sd300;
      run_seg("neg impulse", 32, 1'b0);

      // R3: DC step settles to 512x
      for (int i = 0; i < NMAX; i++) xs[i] = 16'sd1000;
      run_seg("dc 1000", 64, 1'b0);
      check(outs[7] == 25'sd512000, "R3 dc gain", outs[7], 512000);

      // R3 R7: full-scale extremes force integrator wraparound
      for (int i = 0; i < NMAX; i++) xs[i] = -16'sd32768;
      run_seg("dc min", 160, 1'b0);
      check(outs[19] == -25'sd16777216, "R3 R7 dc min", outs[19], -16777216);
      for (int i = 0; i < NMAX; i++) xs[i] = 16'sd32767;
      run_seg("dc max", 160, 1'b1);
      check(outs[19] == 25'sd16776704, "R3 R7 dc max", outs[19], 16776704);

      // R1 R4: pseudo-random stream with gaps
      begin
         logic [31:0] st = 32'h1234_5678;
         for (int i = 0; i < NMAX; i++) begin
            st = st * 32'd1664525 + 32'd1013904223;
            xs[i] = st[31:16];
         end
      end
      run_seg("random", 200, 1'b1);

      // R2: partial group yields nothing
      run_seg("partial", 7, 1'b0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule